// File: doc/BRIEF.md
# Multi-Flag Doorbell Mailbox

This block carries event notifications in one direction, from a sending agent to a receiving agent. Both agents share one clock. It holds a parameterised number of doorbell channels. Each channel has 32 flag bits, and each flag is its own one-bit transfer meaning "an event happened". The sender raises flags through its own small register port. A single write may raise any mix of flags on one channel.

The receiver sees one level interrupt per channel. That interrupt is high while any pending flag of the channel is enabled by the receiver's per-channel enable mask. The receiver reads the pending flags and clears the ones it has handled. A clear that retires at least one pending flag latches an acknowledge condition on the sender side. That condition can raise a per-channel acknowledge interrupt there. The sender can also poll a status register to see which flags are still outstanding. Each side has a combined interrupt, which is the OR of all its per-channel interrupts.

Both register ports use the same layout. The address is `channel * 4 + offset`. A read request returns its data on the read-data output one cycle after the request. Between reads, that output holds its value.

Top module: `dbell_mailbox`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: every pending flag, every receiver enable mask, every acknowledge enable, every acknowledge latch, every interrupt output and both read-data outputs.
- R2: A sender write to offset 0 ORs the write data into that channel's pending flags. Several flags may be raised in one write. Zero bits in the data leave flags unchanged. A flag never becomes pending without such a write.
- R3: A receiver write to offset 1 clears each pending flag whose data bit is 1. Zero bits leave flags unchanged.
- R4: If the sender raises a flag in the same cycle as the receiver clears that same flag, the flag stays pending. That collision alone does not count as an acknowledge.
- R5: A read request latches its data into that side's read-data output at the next clock edge, and the output holds until the next read. The data is the state before that edge. Sender offsets 0 and 1 read the pending flags. Sender offset 2 reads the acknowledge enable in bit 0, and sender offset 3 reads the acknowledge latch in bit 0. Receiver offsets 0 and 1 read the pending flags. Receiver offset 2 reads the enable mask, and receiver offset 3 reads the pending flags ANDed with the enable mask.
- R6: A receiver write to offset 2 loads a channel's 32-bit enable mask, with 1 meaning enabled. The channel's transfer interrupt is high exactly while some flag is both pending and enabled.
- R7: A receiver clear that turns at least one pending flag to 0 sets the channel's acknowledge latch. A sender write to offset 3 with bit 0 set clears the latch; a new acknowledge in the same cycle wins over that clear. A sender write to offset 2 stores bit 0 as the acknowledge enable. The sender acknowledge interrupt of a channel is the latch ANDed with the enable.
- R8: Each side's combined interrupt is high exactly when any of that side's per-channel interrupts is high.
- R9: An address whose channel field is at or above the channel count is ignored on write and reads as zero. An access to one channel never changes another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snd_valid | input | 1 | Sender access request |
| snd_write | input | 1 | Sender access is a write (1) or read (0) |
| snd_addr | input | ADDR_W | Sender address, channel * 4 + offset |
| snd_wdata | input | 32 | Sender write data |
| snd_rdata | output | 32 | Sender read data, one cycle after the request |
| rcv_valid | input | 1 | Receiver access request |
| rcv_write | input | 1 | Receiver access is a write (1) or read (0) |
| rcv_addr | input | ADDR_W | Receiver address, channel * 4 + offset |
| rcv_wdata | input | 32 | Receiver write data |
| rcv_rdata | output | 32 | Receiver read data, one cycle after the request |
| snd_irq_ack | output | NUM_CH | Per-channel acknowledge interrupts on the sender side |
| snd_irq_comb | output | 1 | OR of all sender acknowledge interrupts |
| rcv_irq_xfer | output | NUM_CH | Per-channel transfer interrupts on the receiver side |
| rcv_irq_comb | output | 1 | OR of all receiver transfer interrupts |

## Verification
The assertions check several rules on every cycle:
- Raised flags land.
- A flag never appears without a set.
- A set beats a clear in the same cycle.
- An uncontested clear drops its flags.
- An acknowledge latch rises only after a receiver clear.
- A transfer interrupt holds until a clear or a mask write.
- The combined outputs track the per-channel lines.

Other behaviour is shown only by the bench scenarios, which compare against the behavioural model on every clock:
- The read-data timing and offset layout.
- That out-of-range channels are ignored.
- That channels stay independent.
- That acknowledge enables gate the sender interrupt.
- That a new acknowledge wins over a same-cycle acknowledge clear.

// File: rtl/dbell_pkg.sv
// Package: shared constants, register offsets and helper for the doorbell mailbox.
// Assumes every channel carries a fixed 32-flag word.
package dbell_pkg;

    localparam int FLAG_W = 32;
    localparam int OFF_W  = 2;

    // Sender-side register offsets within one channel window.
    typedef enum logic [OFF_W-1:0] {
        S_RAISE  = 2'd0,
        S_OUTST  = 2'd1,
        S_ACKEN  = 2'd2,
        S_ACKLAT = 2'd3
    } snd_off_e;

    // Receiver-side register offsets within one channel window.
    typedef enum logic [OFF_W-1:0] {
        R_PEND   = 2'd0,
        R_RETIRE = 2'd1,
        R_ENMASK = 2'd2,
        R_ACTIVE = 2'd3
    } rcv_off_e;

    // Width of the channel field; at least one bit.
    function automatic int ch_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dbell_decode.sv
// Module: splits a register-port address into channel and offset, and
// qualifies the access.
// Assumes the address is {channel, offset}. A channel at or above NUM_CH
// is out of range: no write strobe is produced for it.
module dbell_decode #(
    parameter int NUM_CH = 6,
    parameter int CH_W   = 3
) (
    input  logic              valid,
    input  logic              write,
    input  logic [CH_W+1:0]   addr,
    output logic [CH_W-1:0]   ch,
    output logic [1:0]        off,
    output logic              hit,
    output logic              wr_en,
    output logic              rd_en
);

    // Field split and range qualification.
    always_comb begin
        ch    = addr[CH_W+1:2];
        off   = addr[1:0];
        hit   = (32'(ch) < 32'(NUM_CH));
        wr_en = valid && write && hit;
        rd_en = valid && !write;
    end

endmodule

// File: rtl/dbell_channel.sv
// Module: one doorbell channel. It holds the pending flags, the receiver
// enable mask, the acknowledge enable and the acknowledge latch.
// Assumes the strobes are already decoded for this channel. A set beats a
// clear on the same bit.
module dbell_channel #(
    parameter int FLAG_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic [FLAG_W-1:0] set_bits,
    input  logic              clr_we,
    input  logic [FLAG_W-1:0] clr_bits,
    input  logic              mask_we,
    input  logic [FLAG_W-1:0] mask_val,
    input  logic              acken_we,
    input  logic              acken_val,
    input  logic              ackclr_we,
    output logic [FLAG_W-1:0] pend_o,
    output logic [FLAG_W-1:0] mask_o,
    output logic              ack_en_o,
    output logic              ack_pend_o,
    output logic              xfer_irq_o,
    output logic              ack_irq_o
);

    logic [FLAG_W-1:0] set_eff;
    logic [FLAG_W-1:0] clr_eff;
    logic [FLAG_W-1:0] pend_n;
    logic              retire_hit;

    // Effective set and clear vectors, and detection of a real retirement.
    always_comb begin
        set_eff    = set_we ? set_bits : '0;
        clr_eff    = clr_we ? clr_bits : '0;
        pend_n     = (pend_o & ~clr_eff) | set_eff;
        retire_hit = |(pend_o & clr_eff & ~set_eff);
    end

    // Flag storage: clear first, then set, so a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= pend_n;
    end

    // Receiver enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_o <= '0;
        else if (mask_we) mask_o <= mask_val;
    end

    // Sender acknowledge enable.
    always_ff @(posedge clk) begin
        if (!rst_n)        ack_en_o <= 1'b0;
        else if (acken_we) ack_en_o <= acken_val;
    end

    // Acknowledge latch: a new retirement wins over the sender's clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_pend_o <= 1'b0;
        else        ack_pend_o <= retire_hit | (ack_pend_o & ~ackclr_we);
    end

    // Level interrupts of this channel.
    always_comb begin
        xfer_irq_o = |(pend_o & mask_o);
        ack_irq_o  = ack_pend_o & ack_en_o;
    end

    p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((pend_o & $past(set_bits)) == $past(set_bits)));

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !set_we |=> ((pend_o & ~$past(pend_o)) == '0));

    p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((pend_o & $past(clr_bits)) == '0));

    p_set_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && clr_we) |=> ((pend_o & $past(set_bits & clr_bits)) == $past(set_bits & clr_bits)));

    p_xfer_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_irq_o && !clr_we && !mask_we) |=> xfer_irq_o);

    p_ack_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_pend_o) |-> $past(clr_we));

endmodule

// File: rtl/dbell_irq_merge.sv
// Module: ORs a vector of level interrupt sources into one combined line.
// Assumes each source is already gated by its enable.
module dbell_irq_merge #(
    parameter int N = 6
) (
    input  logic [N-1:0] src,
    output logic         any_o
);

    // Reduction OR of all sources.
    always_comb any_o = |src;

endmodule

// File: rtl/dbell_mailbox.sv
// Module: top of the one-way doorbell mailbox. It has a sender register
// port and a receiver register port, NUM_CH channels of 32 flags each,
// per-channel and combined level interrupts on both sides, and read data
// that is registered one cycle after the request.
// Assumes both sides share clk. The address is channel * 4 + offset.
module dbell_mailbox
    import dbell_pkg::*;
#(
    parameter  int NUM_CH = 6,
    localparam int CH_W   = dbell_pkg::ch_bits(NUM_CH),
    localparam int ADDR_W = CH_W + dbell_pkg::OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snd_valid,
    input  logic              snd_write,
    input  logic [ADDR_W-1:0] snd_addr,
    input  logic [31:0]       snd_wdata,
    output logic [31:0]       snd_rdata,
    input  logic              rcv_valid,
    input  logic              rcv_write,
    input  logic [ADDR_W-1:0] rcv_addr,
    input  logic [31:0]       rcv_wdata,
    output logic [31:0]       rcv_rdata,
    output logic [NUM_CH-1:0] snd_irq_ack,
    output logic              snd_irq_comb,
    output logic [NUM_CH-1:0] rcv_irq_xfer,
    output logic              rcv_irq_comb
);

    logic [CH_W-1:0] s_ch, r_ch;
    logic [1:0]      s_off, r_off;
    logic            s_hit, r_hit, s_wr, r_wr, s_rd, r_rd;

    logic [NUM_CH-1:0][FLAG_W-1:0] pend_all;
    logic [NUM_CH-1:0][FLAG_W-1:0] mask_all;
    logic [NUM_CH-1:0]             acken_all;
    logic [NUM_CH-1:0]             ackp_all;

    dbell_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_snd_dec (
        .valid(snd_valid), .write(snd_write), .addr(snd_addr),
        .ch(s_ch), .off(s_off), .hit(s_hit), .wr_en(s_wr), .rd_en(s_rd)
    );

    dbell_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_rcv_dec (
        .valid(rcv_valid), .write(rcv_write), .addr(rcv_addr),
        .ch(r_ch), .off(r_off), .hit(r_hit), .wr_en(r_wr), .rd_en(r_rd)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel_s, sel_r;

        // Channel selection for each side.
        always_comb begin
            sel_s = s_wr && (s_ch == CH_W'(i));
            sel_r = r_wr && (r_ch == CH_W'(i));
        end

        dbell_channel #(.FLAG_W(FLAG_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_we     (sel_s && (s_off == S_RAISE)),
            .set_bits   (snd_wdata),
            .clr_we     (sel_r && (r_off == R_RETIRE)),
            .clr_bits   (rcv_wdata),
            .mask_we    (sel_r && (r_off == R_ENMASK)),
            .mask_val   (rcv_wdata),
            .acken_we   (sel_s && (s_off == S_ACKEN)),
            .acken_val  (snd_wdata[0]),
            .ackclr_we  (sel_s && (s_off == S_ACKLAT) && snd_wdata[0]),
            .pend_o     (pend_all[i]),
            .mask_o     (mask_all[i]),
            .ack_en_o   (acken_all[i]),
            .ack_pend_o (ackp_all[i]),
            .xfer_irq_o (rcv_irq_xfer[i]),
            .ack_irq_o  (snd_irq_ack[i])
        );
    end

    dbell_irq_merge #(.N(NUM_CH)) u_snd_merge (.src(snd_irq_ack),  .any_o(snd_irq_comb));
    dbell_irq_merge #(.N(NUM_CH)) u_rcv_merge (.src(rcv_irq_xfer), .any_o(rcv_irq_comb));

    logic [CH_W-1:0] s_idx, r_idx;
    logic [31:0]     s_rval, r_rval;

    // Sender read multiplexer; out-of-range channels read as zero.
    always_comb begin
        s_idx  = s_hit ? s_ch : '0;
        s_rval = '0;
        if (s_hit) begin
            unique case (s_off)
                S_RAISE, S_OUTST: s_rval = pend_all[s_idx];
                S_ACKEN:          s_rval = {31'b0, acken_all[s_idx]};
                default:          s_rval = {31'b0, ackp_all[s_idx]};
            endcase
        end
    end

    // Receiver read multiplexer; out-of-range channels read as zero.
    always_comb begin
        r_idx  = r_hit ? r_ch : '0;
        r_rval = '0;
        if (r_hit) begin
            unique case (r_off)
                R_PEND, R_RETIRE: r_rval = pend_all[r_idx];
                R_ENMASK:         r_rval = mask_all[r_idx];
                default:          r_rval = pend_all[r_idx] & mask_all[r_idx];
            endcase
        end
    end

    // Registered read data for the sender; holds between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)    snd_rdata <= '0;
        else if (s_rd) snd_rdata <= s_rval;
    end

    // Registered read data for the receiver; holds between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)    rcv_rdata <= '0;
        else if (r_rd) rcv_rdata <= r_rval;
    end

    p_rcv_comb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_irq_comb == (rcv_irq_xfer != '0));

    p_snd_comb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        snd_irq_comb == (snd_irq_ack != '0));

    p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!snd_valid || snd_write) |=> $stable(snd_rdata));

endmodule

// File: tb/tb_dbell_mailbox.sv
// Bench: a behavioural reference model, compared on every clock, plus
// directed scenarios and a random phase.
module tb_dbell_mailbox;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 6;
    localparam int AW         = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          s_valid = 0, s_write = 0, r_valid = 0, r_write = 0;
    logic [AW-1:0] s_addr = '0, r_addr = '0;
    logic [31:0]   s_wdata = '0, r_wdata = '0;
    logic [31:0]   snd_rdata, rcv_rdata;
    logic [NUM_CH-1:0] snd_irq_ack, rcv_irq_xfer;
    logic          snd_irq_comb, rcv_irq_comb;

    dbell_mailbox #(.NUM_CH(NUM_CH)) dut (
        .clk(clk), .rst_n(rst_n),
        .snd_valid(s_valid), .snd_write(s_write), .snd_addr(s_addr),
        .snd_wdata(s_wdata), .snd_rdata(snd_rdata),
        .rcv_valid(r_valid), .rcv_write(r_write), .rcv_addr(r_addr),
        .rcv_wdata(r_wdata), .rcv_rdata(rcv_rdata),
        .snd_irq_ack(snd_irq_ack), .snd_irq_comb(snd_irq_comb),
        .rcv_irq_xfer(rcv_irq_xfer), .rcv_irq_comb(rcv_irq_comb)
    );

    logic [31:0] m_pend [NUM_CH];
    logic [31:0] m_mask [NUM_CH];
    logic        m_acken[NUM_CH];
    logic        m_ackp [NUM_CH];
    logic [31:0] m_srd, m_rrd;
    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] A(input int ch, input int off);
        return AW'((ch << 2) | off);
    endfunction

    // Model update from the inputs sampled at this edge.
    task automatic model_edge();
        int sc = int'(s_addr) >> 2;
        int so = int'(s_addr) & 3;
        int rc = int'(r_addr) >> 2;
        int ro = int'(r_addr) & 3;
        if (s_valid && !s_write) begin
            m_srd = 0;
            if (sc < NUM_CH) begin
                if (so <= 1)      m_srd = m_pend[sc];
                else if (so == 2) m_srd = {31'b0, m_acken[sc]};
                else              m_srd = {31'b0, m_ackp[sc]};
            end
        end
        if (r_valid && !r_write) begin
            m_rrd = 0;
            if (rc < NUM_CH) begin
                if (ro <= 1)      m_rrd = m_pend[rc];
                else if (ro == 2) m_rrd = m_mask[rc];
                else              m_rrd = m_pend[rc] & m_mask[rc];
            end
        end
        for (int c = 0; c < NUM_CH; c++) begin
            logic [31:0] st, cl;
            logic hit, ackclr;
            st = (s_valid && s_write && sc == c && so == 0) ? s_wdata : 32'h0;
            cl = (r_valid && r_write && rc == c && ro == 1) ? r_wdata : 32'h0;
            hit = |(m_pend[c] & cl & ~st);
            ackclr = s_valid && s_write && sc == c && so == 3 && s_wdata[0];
            m_pend[c] = (m_pend[c] & ~cl) | st;
            if (r_valid && r_write && rc == c && ro == 2) m_mask[c] = r_wdata;
            if (s_valid && s_write && sc == c && so == 2) m_acken[c] = s_wdata[0];
            m_ackp[c] = hit | (m_ackp[c] & ~ackclr);
        end
    endtask

    task automatic compare_all();
        logic [NUM_CH-1:0] ex, ea;
        for (int c = 0; c < NUM_CH; c++) begin
            ex[c] = |(m_pend[c] & m_mask[c]);
            ea[c] = m_ackp[c] & m_acken[c];
        end
        chk("R6 rcv_irq_xfer", 32'(rcv_irq_xfer), 32'(ex));
        chk("R7 snd_irq_ack", 32'(snd_irq_ack), 32'(ea));
        chk("R8 rcv_irq_comb", 32'(rcv_irq_comb), 32'(|ex));
        chk("R8 snd_irq_comb", 32'(snd_irq_comb), 32'(|ea));
        chk("R5 snd_rdata", snd_rdata, m_srd);
        chk("R5 rcv_rdata", rcv_rdata, m_rrd);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
        s_valid = 0; r_valid = 0;
    endtask

    task automatic s_wr(input logic [AW-1:0] a, input logic [31:0] d);
        s_valid = 1; s_write = 1; s_addr = a; s_wdata = d; step();
    endtask

    task automatic r_wr(input logic [AW-1:0] a, input logic [31:0] d);
        r_valid = 1; r_write = 1; r_addr = a; r_wdata = d; step();
    endtask

    task automatic s_rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        s_valid = 1; s_write = 0; s_addr = a; step(); chk(tag, snd_rdata, exp);
    endtask

    task automatic r_rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        r_valid = 1; r_write = 0; r_addr = a; step(); chk(tag, rcv_rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < NUM_CH; c++) begin
            m_pend[c] = 0; m_mask[c] = 0; m_acken[c] = 0; m_ackp[c] = 0;
        end
        m_srd = 0; m_rrd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        // R1: reset state
        chk("R1 snd_irq_comb", 32'(snd_irq_comb), 0);
        chk("R1 rcv_irq_xfer", 32'(rcv_irq_xfer), 0);
        s_rd(A(0, 1), 32'h0, "R1 pending ch0");
        r_rd(A(3, 2), 32'h0, "R1 mask ch3");
        // R2: raise several flags, accumulate, zero write no effect
        s_wr(A(0, 0), 32'h0000_0005);
        s_rd(A(0, 1), 32'h0000_0005, "R2 multi-flag set");
        s_wr(A(0, 0), 32'h0000_0100);
        s_wr(A(0, 0), 32'h0);
        r_rd(A(0, 0), 32'h0000_0105, "R2 accumulate and zero write");
        // R6: mask gating
        chk("R6 masked off", 32'(rcv_irq_xfer), 0);
        r_wr(A(0, 2), 32'h0000_0004);
        chk("R6 enabled", 32'(rcv_irq_xfer), 32'h1);
        r_rd(A(0, 3), 32'h0000_0004, "R6 active view");
        // R3 and R7: clear one flag, acknowledge path
        r_wr(A(0, 1), 32'h0000_0001);
        s_rd(A(0, 1), 32'h0000_0104, "R3 clear one flag");
        s_rd(A(0, 3), 32'h1, "R7 ack latch set");
        chk("R7 ack gated off", 32'(snd_irq_ack), 0);
        s_wr(A(0, 2), 32'h1);
        chk("R7 ack irq on", 32'(snd_irq_ack), 32'h1);
        s_wr(A(0, 3), 32'h1);
        chk("R7 ack cleared", 32'(snd_irq_ack), 0);
        r_wr(A(0, 1), 32'h0000_0000);
        s_rd(A(0, 1), 32'h0000_0104, "R3 zero clear no effect");
        // R4: same-cycle set and clear
        s_wr(A(1, 0), 32'h0000_0010);
        s_valid = 1; s_write = 1; s_addr = A(1, 0); s_wdata = 32'h0000_0010;
        r_valid = 1; r_write = 1; r_addr = A(1, 1); r_wdata = 32'h0000_0010;
        step();
        r_rd(A(1, 0), 32'h0000_0010, "R4 set wins");
        s_rd(A(1, 3), 32'h0, "R4 no ack on collision");
        // R7: new ack wins over ack clear in the same cycle
        s_valid = 1; s_write = 1; s_addr = A(0, 3); s_wdata = 32'h1;
        r_valid = 1; r_write = 1; r_addr = A(0, 1); r_wdata = 32'h0000_0004;
        step();
        s_rd(A(0, 3), 32'h1, "R7 ack beats clear");
        // R9: out-of-range channels and independence
        s_wr(A(6, 0), 32'hFFFF_FFFF);
        r_wr(A(7, 2), 32'hFFFF_FFFF);
        s_rd(A(6, 1), 32'h0, "R9 oob read zero");
        r_rd(A(7, 2), 32'h0, "R9 oob mask zero");
        r_rd(A(2, 0), 32'h0, "R9 other channel untouched");
        // R8: combined across channels
        r_wr(A(1, 2), 32'h0000_0010);
        chk("R8 comb multi", 32'(rcv_irq_comb), 1);
        // random phase, model compared on every clock
        for (int i = 0; i < 600; i++) begin
            s_valid = 1'($urandom_range(0, 1)); s_write = 1'($urandom_range(0, 1));
            s_addr = AW'($urandom_range(0, 31)); s_wdata = $urandom & 32'h0000_00FF;
            r_valid = 1'($urandom_range(0, 1)); r_write = 1'($urandom_range(0, 1));
            r_addr = AW'($urandom_range(0, 31)); r_wdata = $urandom & 32'h0000_00FF;
            step();
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule